// File: doc/BRIEF.md
# Dot-Matrix Refresh Engine with Dimming, Flash and Blink

This block drives eight 5x7 character cells from stored character codes. It scans fourteen row strobes, seven rows for the left group of four characters and then seven for the right group. It also drives twenty column enables, five for each of the four characters in the active group. For every character it reads the character store. If bit 7 of the code is clear, it looks up a 7-bit code in an external font lookup port. If bit 7 is set, it reads a row of one of sixteen custom glyphs.

A prescaler splits time into row periods. In the first four cycles of a row period, a small fetch machine collects the column pattern of the next row. The pattern is loaded into the column register at the row boundary, so rows and columns change together. The column enables are then trimmed by a brightness duty setting and by a slow visibility phase. That phase gates single flagged characters (flash) or the whole display (blink).

The fetch machine has two states. FS_FETCH reads one character per cycle. When it has read the fourth character, the FETCH_DONE transition moves it to FS_HOLD. FS_HOLD waits, and at the last cycle of the row period the ROW_START transition returns it to FS_FETCH.

Top module: `dotmatrix_refresh`

## Requirements
- R1: While reset is active, and in the first cycle after it, the left-group first row strobe (bit 0) is the only strobe active and every column enable is off. All divider counters and the visibility phase start at zero (visible).
- R2: Exactly one of the 14 row strobes is active at any time. Strobe index = group*7 + row. Each strobe is held for PRE_DIV cycles, and the order is rows 0..6 of group 0 (characters 0-3), then rows 0..6 of group 1 (characters 4-7).
- R3: Column enable bit d*5+j shows column j+1 of character group*4+d for the active row. Column 1 is pattern bit 4 and column 5 is pattern bit 0, and a 1 lights the dot. A code with bit 7 clear sends bits 6..0 to rom_code, and the pattern is taken from rom_cols. A code with bit 7 set sends bits 3..0 to glyph_idx, and the pattern is taken from glyph_cols. Both ports receive the row number.
- R4: The columns shown in a row period are fetched during the previous row period. Character k of the next row is read at char_addr = {next group, k} in cycle k (k = 0..3) of that period.
- R5: Brightness code ctrl_attr[2:0] = c enables the columns only in the cycles of a row period whose position p satisfies p*15 < N(c)*PRE_DIV. N is 15, 12, 8, 6, 4, 3, 2, 0 for c = 0..7.
- R6: Brightness code 3'b111 keeps every column enable off.
- R7: With ctrl_attr[3] set and ctrl_attr[4] clear, the columns of a character whose flash_bits bit (index = character number) is 1 are off while the phase is 1. Other characters are not affected.
- R8: With ctrl_attr[4] set, all columns are off while the phase is 1.
- R9: Blink has priority over flash. With both bits set, characters whose flash bit is clear also go dark while the phase is 1.
- R10: The visibility phase toggles once every PRE_DIV*14*FLASH_DIV cycles (28,672 with default values), always at the start of a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Refresh clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctrl_attr | input | 5 | [2:0] brightness code, [3] flash enable, [4] blink enable |
| flash_bits | input | 8 | Per-character flash flags, bit n = character n |
| char_addr | output | 3 | Character store read address |
| char_data | input | 8 | Character code at char_addr (same cycle) |
| rom_code | output | 7 | Font lookup code |
| rom_row | output | 3 | Font lookup row |
| rom_cols | input | 5 | Font row pattern, bit 4 = column 1 |
| glyph_idx | output | 4 | Custom glyph index |
| glyph_row | output | 3 | Custom glyph row |
| glyph_cols | input | 5 | Custom glyph row pattern, bit 4 = column 1 |
| row_strobe | output | 14 | One-hot row strobes |
| col_drive | output | 20 | Column enables for the active group |

## Verification
The bench builds the block with PRE_DIV = 15 and FLASH_DIV = 2. With a 15-cycle row period, the duty rule reduces to "on while position < N", so each brightness step is visible as a whole number of cycles. A 420-cycle phase period brings several flash and blink toggles within a few thousand cycles. The character store is also rewritten at odd intervals, so a change that lands before, inside or after the four fetch cycles tests the one-row look-ahead.

// File: rtl/dm_pkg.sv
package dm_pkg;

    localparam int ROWS       = 7;
    localparam int GROUPS     = 2;
    localparam int CHARS_GRP  = 4;
    localparam int GLYPH_W    = 5;
    localparam int SUBSLOTS   = 15;
    localparam int STROBES    = ROWS * GROUPS;
    localparam int COL_W      = CHARS_GRP * GLYPH_W;
    localparam int CHARS      = CHARS_GRP * GROUPS;

    typedef enum logic [0:0] {
        FS_FETCH = 1'b0,
        FS_HOLD  = 1'b1
    } fetch_state_t;

    // Number of lit sub-slots out of SUBSLOTS for a brightness code.
    function automatic int unsigned duty_steps(input logic [2:0] code);
        int unsigned n;
        unique case (code)
            3'd0: n = 15;
            3'd1: n = 12;
            3'd2: n = 8;
            3'd3: n = 6;
            3'd4: n = 4;
            3'd5: n = 3;
            3'd6: n = 2;
            default: n = 0;
        endcase
        return n;
    endfunction

    // Pattern bit 4 is column 1; drive bit j is column j+1.
    function automatic logic [GLYPH_W-1:0] to_drive_order(input logic [GLYPH_W-1:0] pat);
        logic [GLYPH_W-1:0] r;
        for (int j = 0; j < GLYPH_W; j++) begin
            r[j] = pat[GLYPH_W-1-j];
        end
        return r;
    endfunction

endpackage

// File: rtl/dm_timebase.sv
module dm_timebase
    import dm_pkg::*;
#(
    parameter int PRE_DIV   = 32,
    parameter int FLASH_DIV = 64,
    localparam int PW = $clog2(PRE_DIV),
    localparam int FW = $clog2(FLASH_DIV)
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic [PW-1:0] pre_cnt,
    output logic [2:0]    row_idx,
    output logic          grp_idx,
    output logic          row_end,
    output logic          phase
);

    logic [FW-1:0] frame_cnt;

    assign row_end = (pre_cnt == PW'(PRE_DIV - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_cnt   <= '0;
            row_idx   <= '0;
            grp_idx   <= 1'b0;
            frame_cnt <= '0;
            phase     <= 1'b0;
        end else if (row_end) begin
            pre_cnt <= '0;
            if (row_idx == 3'(ROWS - 1)) begin
                row_idx <= '0;
                grp_idx <= ~grp_idx;
                if (grp_idx) begin
                    if (frame_cnt == FW'(FLASH_DIV - 1)) begin
                        frame_cnt <= '0;
                        phase     <= ~phase;
                    end else begin
                        frame_cnt <= frame_cnt + 1'b1;
                    end
                end
            end else begin
                row_idx <= row_idx + 1'b1;
            end
        end else begin
            pre_cnt <= pre_cnt + 1'b1;
        end
    end

    // R10: the phase only moves at the first cycle of a frame
    a_r10_phase_at_frame_start: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(phase) |-> (pre_cnt == '0 && row_idx == 3'd0 && grp_idx == 1'b0));

endmodule

// File: rtl/dm_fetch.sv
module dm_fetch
    import dm_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [2:0]       row_idx,
    input  logic             grp_idx,
    input  logic             row_end,
    output logic [2:0]       char_addr,
    input  logic [7:0]       char_data,
    output logic [6:0]       rom_code,
    output logic [2:0]       rom_row,
    input  logic [4:0]       rom_cols,
    output logic [3:0]       glyph_idx,
    output logic [2:0]       glyph_row,
    input  logic [4:0]       glyph_cols,
    output logic [COL_W-1:0] cur_cols
);

    fetch_state_t         state;
    logic [1:0]           fidx;
    logic [COL_W-1:0]     stage;
    logic [2:0]           next_row;
    logic                 next_grp;
    logic [GLYPH_W-1:0]   pix;

    always_comb begin
        if (row_idx == 3'(ROWS - 1)) begin
            next_row = 3'd0;
            next_grp = ~grp_idx;
        end else begin
            next_row = row_idx + 1'b1;
            next_grp = grp_idx;
        end
    end

    assign char_addr = {next_grp, fidx};
    assign rom_code  = char_data[6:0];
    assign rom_row   = next_row;
    assign glyph_idx = char_data[3:0];
    assign glyph_row = next_row;
    assign pix       = char_data[7] ? glyph_cols : rom_cols;

    // State register: FETCH_DONE and ROW_START transitions
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= FS_FETCH;
        end else begin
            unique case (state)
                FS_FETCH: if (fidx == 2'(CHARS_GRP - 1)) state <= FS_HOLD;
                FS_HOLD:  if (row_end)                   state <= FS_FETCH;
                default:                                 state <= FS_FETCH;
            endcase
        end
    end

    // Datapath driven by the state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fidx     <= '0;
            stage    <= '0;
            cur_cols <= '0;
        end else begin
            unique case (state)
                FS_FETCH: begin
                    for (int k = 0; k < CHARS_GRP; k++) begin
                        if (fidx == 2'(k)) begin
                            stage[k*GLYPH_W +: GLYPH_W] <= to_drive_order(pix);
                        end
                    end
                    fidx <= fidx + 1'b1;
                end
                FS_HOLD: begin
                    fidx <= '0;
                end
                default: fidx <= '0;
            endcase
            if (row_end) begin
                cur_cols <= stage;
            end
        end
    end

    // R4: all four characters are fetched before the row boundary
    a_r4_fetch_before_boundary: assert property (@(posedge clk) disable iff (!rst_n)
        row_end |-> (state == FS_HOLD));

    // R4: columns move only at a row boundary
    a_r4_cols_stable_in_row: assert property (@(posedge clk) disable iff (!rst_n)
        !row_end |=> $stable(cur_cols));

endmodule

// File: rtl/dm_colgate.sv
module dm_colgate
    import dm_pkg::*;
#(
    parameter int PRE_DIV = 32,
    localparam int PW = $clog2(PRE_DIV)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PW-1:0]    pre_cnt,
    input  logic             grp_idx,
    input  logic             phase,
    input  logic [4:0]       ctrl_attr,
    input  logic [CHARS-1:0] flash_bits,
    input  logic [COL_W-1:0] cur_cols,
    output logic [COL_W-1:0] col_drive
);

    logic duty_on;
    logic blink_dark;

    assign duty_on    = (int'(pre_cnt) * SUBSLOTS) < (int'(duty_steps(ctrl_attr[2:0])) * PRE_DIV);
    assign blink_dark = ctrl_attr[4] & phase;

    for (genvar d = 0; d < CHARS_GRP; d++) begin : g_char
        logic flag;
        logic flash_dark;
        logic lit;
        assign flag       = flash_bits[{grp_idx, 2'(d)}];
        assign flash_dark = ctrl_attr[3] & flag & phase;
        assign lit        = duty_on & ~(blink_dark | flash_dark);
        assign col_drive[d*GLYPH_W +: GLYPH_W] = cur_cols[d*GLYPH_W +: GLYPH_W] & {GLYPH_W{lit}};
    end

    // R6: blank code keeps every column off
    a_r6_blank_code: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_attr[2:0] == 3'b111) |-> (col_drive == '0));

    // R8: blink dark phase keeps every column off
    a_r8_blink_dark: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_attr[4] && phase) |-> (col_drive == '0));

endmodule

// File: rtl/dotmatrix_refresh.sv
module dotmatrix_refresh
    import dm_pkg::*;
#(
    parameter int PRE_DIV   = 32,
    parameter int FLASH_DIV = 64,
    localparam int PW = $clog2(PRE_DIV)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [4:0]   ctrl_attr,
    input  logic [7:0]   flash_bits,
    output logic [2:0]   char_addr,
    input  logic [7:0]   char_data,
    output logic [6:0]   rom_code,
    output logic [2:0]   rom_row,
    input  logic [4:0]   rom_cols,
    output logic [3:0]   glyph_idx,
    output logic [2:0]   glyph_row,
    input  logic [4:0]   glyph_cols,
    output logic [13:0]  row_strobe,
    output logic [19:0]  col_drive
);

    logic [PW-1:0]    pre_cnt;
    logic [2:0]       row_idx;
    logic             grp_idx;
    logic             row_end;
    logic             phase;
    logic [COL_W-1:0] cur_cols;

    dm_timebase #(.PRE_DIV(PRE_DIV), .FLASH_DIV(FLASH_DIV)) u_tb (
        .clk     (clk),
        .rst_n   (rst_n),
        .pre_cnt (pre_cnt),
        .row_idx (row_idx),
        .grp_idx (grp_idx),
        .row_end (row_end),
        .phase   (phase)
    );

    dm_fetch u_fetch (
        .clk        (clk),
        .rst_n      (rst_n),
        .row_idx    (row_idx),
        .grp_idx    (grp_idx),
        .row_end    (row_end),
        .char_addr  (char_addr),
        .char_data  (char_data),
        .rom_code   (rom_code),
        .rom_row    (rom_row),
        .rom_cols   (rom_cols),
        .glyph_idx  (glyph_idx),
        .glyph_row  (glyph_row),
        .glyph_cols (glyph_cols),
        .cur_cols   (cur_cols)
    );

    dm_colgate #(.PRE_DIV(PRE_DIV)) u_gate (
        .clk        (clk),
        .rst_n      (rst_n),
        .pre_cnt    (pre_cnt),
        .grp_idx    (grp_idx),
        .phase      (phase),
        .ctrl_attr  (ctrl_attr),
        .flash_bits (flash_bits),
        .cur_cols   (cur_cols),
        .col_drive  (col_drive)
    );

    always_comb begin
        row_strobe = '0;
        row_strobe[int'(grp_idx) * ROWS + int'(row_idx)] = 1'b1;
    end

    // R2: exactly one strobe active
    a_r2_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(row_strobe) == 1);

    // R2: a strobe is held for the whole row period
    a_r2_strobe_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (pre_cnt != '0) |-> $stable(row_strobe));

endmodule

// File: tb/sim_dotmatrix_refresh.sv
module sim_dotmatrix_refresh;

    localparam int P = 15;
    localparam int F = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  ctrl_attr = '0;
    logic [7:0]  flash_bits = '0;
    logic [2:0]  char_addr;
    logic [7:0]  char_data;
    logic [6:0]  rom_code;
    logic [2:0]  rom_row;
    logic [4:0]  rom_cols;
    logic [3:0]  glyph_idx;
    logic [2:0]  glyph_row;
    logic [4:0]  glyph_cols;
    logic [13:0] row_strobe;
    logic [19:0] col_drive;

    logic [7:0] cram [8];

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;
    string cur_req = "R3 R4 R5";

    always #10 clk = ~clk;

    function automatic logic [4:0] font_fn(input logic [6:0] code, input logic [2:0] row);
        return 5'((int'(code) * 7 + int'(row) * 13 + 3) % 32);
    endfunction

    function automatic logic [4:0] glyph_fn(input logic [3:0] idx, input logic [2:0] row);
        return 5'((int'(idx) * 11 + int'(row) * 5 + 17) % 32);
    endfunction

    assign char_data  = cram[char_addr];
    assign rom_cols   = font_fn(rom_code, rom_row);
    assign glyph_cols = glyph_fn(glyph_idx, glyph_row);

    dotmatrix_refresh #(.PRE_DIV(P), .FLASH_DIV(F)) u0 (
        .clk(clk), .rst_n(rst_n), .ctrl_attr(ctrl_attr), .flash_bits(flash_bits),
        .char_addr(char_addr), .char_data(char_data),
        .rom_code(rom_code), .rom_row(rom_row), .rom_cols(rom_cols),
        .glyph_idx(glyph_idx), .glyph_row(glyph_row), .glyph_cols(glyph_cols),
        .row_strobe(row_strobe), .col_drive(col_drive)
    );

    // Behavioural reference model
    int m_pre, m_row, m_grp, m_frame, m_phase;
    int m_cols [4];
    int m_stage [4];

    function automatic int char_pattern(input logic [7:0] c, input int row);
        logic [4:0] p;
        if (c[7]) p = glyph_fn(c[3:0], 3'(row));
        else      p = font_fn(c[6:0], 3'(row));
        return int'(p);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_pre = 0; m_row = 0; m_grp = 0; m_frame = 0; m_phase = 0;
            foreach (m_cols[i]) begin m_cols[i] = 0; m_stage[i] = 0; end
        end else begin
            int nr, ng;
            nr = (m_row == 6) ? 0 : m_row + 1;
            ng = (m_row == 6) ? 1 - m_grp : m_grp;
            if (m_pre < 4) m_stage[m_pre] = char_pattern(cram[ng*4 + m_pre], nr);
            if (m_pre == P - 1) begin
                m_pre = 0;
                foreach (m_cols[i]) m_cols[i] = m_stage[i];
                if (m_row == 6 && m_grp == 1) begin
                    m_frame++;
                    if (m_frame == F) begin m_frame = 0; m_phase = 1 - m_phase; end
                end
                m_row = nr; m_grp = ng;
            end else begin
                m_pre++;
            end
        end
    end

    function automatic logic [19:0] exp_cols();
        int steps [8] = '{15, 12, 8, 6, 4, 3, 2, 0};
        logic [19:0] r = '0;
        bit on = (m_pre * 15) < (steps[ctrl_attr[2:0]] * P);
        for (int d = 0; d < 4; d++) begin
            bit dark = (m_phase == 1) &&
                       (ctrl_attr[4] || (ctrl_attr[3] && flash_bits[m_grp*4 + d]));
            for (int j = 0; j < 5; j++) begin
                r[d*5 + j] = on && !dark && m_cols[d][4-j];
            end
        end
        return r;
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s at %0t: actual %h expected %h", tag, $time, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !done) begin
            logic [13:0] er;
            er = '0;
            er[m_grp*7 + m_row] = 1'b1;
            check("R2 strobe", 32'(row_strobe), 32'(er));
            check(cur_req, 32'(col_drive), 32'(exp_cols()));
        end
    end

    task automatic run(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic report();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        #(200000 * 20);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            done = 1;
            report();
        end
    end

    initial begin
        cram = '{8'h41, 8'h2A, 8'h13, 8'h7F, 8'h05, 8'h60, 8'h38, 8'h22};
        run(3);
        // R1: reset state
        check("R1 strobe in reset", 32'(row_strobe), 32'h1);
        check("R1 cols in reset", 32'(col_drive), 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 strobe after reset", 32'(row_strobe), 32'h1);
        check("R1 cols after reset", 32'(col_drive), 32'h0);
        cur_req = "R3 R4 R5";
        run(900);
        // R5: every brightness step
        for (int c = 1; c < 7; c++) begin
            ctrl_attr = 5'(c);
            cur_req = "R5 duty";
            run(250);
        end
        // R6: blank code
        ctrl_attr = 5'b00111;
        cur_req = "R6 blank";
        run(300);
        // R3: custom glyphs mixed with font codes
        ctrl_attr = 5'b00000;
        cram = '{8'h85, 8'h41, 8'h8F, 8'h80, 8'h33, 8'h8A, 8'h7E, 8'h91};
        cur_req = "R3 glyph";
        run(450);
        // R7, R10: flash on flagged characters
        ctrl_attr = 5'b01001;
        flash_bits = 8'b1010_0101;
        cur_req = "R7 R10 flash";
        run(900);
        // R8, R9: blink overrides flash
        ctrl_attr = 5'b11000;
        cur_req = "R8 R9 blink";
        run(900);
        // R4: store rewritten at odd moments
        ctrl_attr = 5'b00010;
        flash_bits = 8'h00;
        cur_req = "R4 lookahead";
        for (int i = 0; i < 24; i++) begin
            cram[i % 8] = 8'((i * 37 + 11) % 256);
            run(23 + (i % 5));
        end
        done = 1;
        report();
    end

endmodule